// File: doc/BRIEF.md
# Timer Status Flags with Halt-Safe Clearing

This block holds the event flags of a multi-channel timer and turns them into one interrupt request. It contains the free-running modulo counter. An overflow flag sets when that counter reaches the programmed limit, and each of six channels has a flag that its capture or compare event sets. Every flag has its own interrupt enable. The request output is the OR of all flags whose enable is 1.

Software clears a flag in two steps. First it reads the status while the flag is 1, which arms that flag. Then it writes 0 to that flag's bit.

Two more inputs control the counter. A debug-halt input freezes the counter and discards capture events. A clear-permit input decides whether register accesses made during the halt may touch the flags. With clear-permit at 0, a read done before the halt stays valid, so the write of 0 made after the halt still clears the flag. A stop input holds the counter and all flags unchanged and ignores every event until it drops. There is no wait-mode input: in wait mode the counter runs and the request stays live without any extra logic. A per-channel output-forcing path drives a channel's pin high while both its maximum-duty bit and its overflow-toggle bit are set.

All pins are plain control and status signals with no valid/ready flow. The register port is a pair of one-cycle strobes that always take effect.

Top module: `tmr_flag_ctl`

## Requirements
- R1: While neither halt nor stop is active, the counter rises by one per clock. On the edge where it equals `mod_val`, it loads 0 instead and status bit 6 (overflow) becomes 1.
- R2: A 1 on `ch_evt_i[k]` for one clock sets status bit k (k = 0..5) at that edge, unless halt or stop blocks it.
- R3: `irq_o` is 1 exactly when some status bit i and `ien_i[i]` are both 1. Enable bit i uses the same position as status bit i.
- R4: A status read while bit i is 1 arms bit i. A later write whose bit i is 0 clears an armed flag. A write with bit i at 1 leaves the flag set. Any write that is accepted disarms all flags, and a write to a flag that is not armed has no effect.
- R5: If a set event and a clearing write hit the same flag at the same edge, the flag stays 1.
- R6: While `halt_i` is 1, the counter holds its value. Events on channels with `ch_is_cap_i[k]`=1 are ignored, and compare-channel events still set their flags.
- R7: While `halt_i` is 1 and `clr_en_i` is 0, reads and writes neither change nor arm any flag. An arm made before the halt survives, and a write of 0 after the halt clears the flag.
- R8: While `halt_i` is 1 and `clr_en_i` is 1, the two-step clear works, and a flag cleared then is still 0 after the halt ends.
- R9: While `stop_i` is 1, the counter and all flags hold and every event is ignored. Counting resumes from the held value when stop drops.
- R10: `pin_o[k]` is 1 whenever `max_duty_i[k]` and `tov_i[k]` are both 1. Otherwise it equals `cmp_pin_i[k]`.
- R11: Reset sets the counter, all flags and all arm bits to 0, so `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_val | input | 16 | Counter limit |
| halt_i | input | 1 | Debug halt |
| clr_en_i | input | 1 | Permits flag clearing during halt |
| stop_i | input | 1 | Low-power stop |
| ch_evt_i | input | 6 | Per-channel event pulses |
| ch_is_cap_i | input | 6 | Channel works as input capture |
| ien_i | input | 7 | Interrupt enables, bit 6 overflow |
| rd_stat_i | input | 1 | Status read strobe |
| wr_stat_i | input | 1 | Status write strobe |
| wr_data_i | input | 7 | Status write data |
| max_duty_i | input | 6 | Per-channel maximum-duty bit |
| tov_i | input | 6 | Per-channel toggle-on-overflow bit |
| cmp_pin_i | input | 6 | Compare pin value from channel logic |
| cnt_o | output | 16 | Counter value |
| stat_o | output | 7 | Flags, bit 6 overflow, bits 5:0 channels |
| irq_o | output | 1 | Interrupt request |
| pin_o | output | 6 | Channel output pins |

## Verification
A wrongly kept arm bit shows up only later. It appears as a write of 0 that clears, or fails to clear, a flag one edge after that write. For that reason the clearing tests always place a status read before a write, or deliberately leave it out, and compare `stat_o` on the next cycle. A counter that miscounts or fails to freeze shows at `cnt_o` on the first edge. A wrong wrap also shows on the overflow bit at that same edge. Flags that change during a protected halt show on `stat_o` at once, and their arm state shows at the first write after the halt.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  typedef enum logic [1:0] {
    CTR_RUN  = 2'd0,
    CTR_HALT = 2'd1,
    CTR_STOP = 2'd2
  } ctr_mode_e;
endpackage

// File: rtl/tmr_mod_counter.sv
module tmr_mod_counter
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctr_mode_e        mode,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  logic at_limit;
  assign at_limit = (cnt == mod_val);
  assign wrap_evt = (mode == CTR_RUN) && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (mode == CTR_RUN) begin
      cnt <= at_limit ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic acc_ok,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (set_evt) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (wr_stb && acc_ok) begin
      if (!wr_bit && armed) flag <= 1'b0;
      armed <= 1'b0;
    end else if (rd_stb && acc_ok && flag) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 6,
  localparam int NFL  = NCH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] mod_val,
  input  logic             halt_i,
  input  logic             clr_en_i,
  input  logic             stop_i,
  input  logic [NCH-1:0]   ch_evt_i,
  input  logic [NCH-1:0]   ch_is_cap_i,
  input  logic [NFL-1:0]   ien_i,
  input  logic             rd_stat_i,
  input  logic             wr_stat_i,
  input  logic [NFL-1:0]   wr_data_i,
  input  logic [NCH-1:0]   max_duty_i,
  input  logic [NCH-1:0]   tov_i,
  input  logic [NCH-1:0]   cmp_pin_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [NFL-1:0]   stat_o,
  output logic             irq_o,
  output logic [NCH-1:0]   pin_o
);
  ctr_mode_e      mode;
  logic           wrap_evt;
  logic           acc_ok;
  logic [NFL-1:0] set_vec;

  always_comb begin
    if (stop_i)      mode = CTR_STOP;
    else if (halt_i) mode = CTR_HALT;
    else             mode = CTR_RUN;
  end

  assign acc_ok = !halt_i || clr_en_i;

  tmr_mod_counter #(.CNT_W(CNT_W)) ctr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .mod_val  (mod_val),
    .cnt      (cnt_o),
    .wrap_evt (wrap_evt)
  );

  assign set_vec[NCH] = wrap_evt;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign set_vec[k] = ch_evt_i[k] && (mode != CTR_STOP) &&
                        !((mode == CTR_HALT) && ch_is_cap_i[k]);
    assign pin_o[k]   = (max_duty_i[k] && tov_i[k]) || cmp_pin_i[k];
  end

  for (genvar i = 0; i < NFL; i++) begin : g_flag
    tmr_flag_cell cell_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_vec[i]),
      .acc_ok  (acc_ok && !stop_i),
      .rd_stb  (rd_stat_i),
      .wr_stb  (wr_stat_i),
      .wr_bit  (wr_data_i[i]),
      .flag    (stat_o[i])
    );
  end

  assign irq_o = |(stat_o & ien_i);
endmodule

// File: rtl/tmr_flag_chk.sv
module tmr_flag_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 6,
  localparam int NFL  = NCH + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] mod_val,
  input logic             halt_i,
  input logic             clr_en_i,
  input logic             stop_i,
  input logic [NCH-1:0]   ch_evt_i,
  input logic [NFL-1:0]   ien_i,
  input logic [NCH-1:0]   max_duty_i,
  input logic [NCH-1:0]   tov_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [NFL-1:0]   stat_o,
  input logic             irq_o,
  input logic [NCH-1:0]   pin_o
);
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_i && !stop_i && cnt_o == mod_val) |=> (cnt_o == '0 && stat_o[NCH])); // R1
  AST_CH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_i && !stop_i) |=> ((stat_o[NCH-1:0] & $past(ch_evt_i)) == $past(ch_evt_i))); // R2
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_i == '0) |-> !irq_o); // R3
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (cnt_o == $past(cnt_o))); // R6
  AST_HALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !clr_en_i) |=> ((~stat_o & $past(stat_o)) == '0)); // R7
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> ($stable(cnt_o) && $stable(stat_o))); // R9
  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_o | ~(max_duty_i & tov_i)) == '1)); // R10
endmodule

bind tmr_flag_ctl tmr_flag_chk #(.CNT_W(CNT_W), .NCH(NCH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mod_val    (mod_val),
  .halt_i     (halt_i),
  .clr_en_i   (clr_en_i),
  .stop_i     (stop_i),
  .ch_evt_i   (ch_evt_i),
  .ien_i      (ien_i),
  .max_duty_i (max_duty_i),
  .tov_i      (tov_i),
  .cnt_o      (cnt_o),
  .stat_o     (stat_o),
  .irq_o      (irq_o),
  .pin_o      (pin_o)
);

// File: tb/tmr_flag_ctl_tb_top.sv
module tmr_flag_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mod_val = 16'd4;
  logic        halt_i = 1'b0, clr_en_i = 1'b0, stop_i = 1'b0;
  logic [5:0]  ch_evt_i = '0, ch_is_cap_i = '0;
  logic [6:0]  ien_i = '0;
  logic        rd_stat_i = 1'b0, wr_stat_i = 1'b0;
  logic [6:0]  wr_data_i = '0;
  logic [5:0]  max_duty_i = '0, tov_i = '0, cmp_pin_i = '0;
  logic [15:0] cnt_o;
  logic [6:0]  stat_o;
  logic        irq_o;
  logic [5:0]  pin_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] held;

  always #10 clk = ~clk;

  tmr_flag_ctl dut_i (.*);

  // {ev[5:0], ien[6:0], irq}
  localparam logic [13:0] VEC [9] = '{
    {6'b000001, 7'b0000001, 1'b1},
    {6'b000001, 7'b1111110, 1'b0},
    {6'b100000, 7'b0100000, 1'b1},
    {6'b100000, 7'b1011111, 1'b0},
    {6'b010100, 7'b0000100, 1'b1},
    {6'b010100, 7'b0101011, 1'b0},
    {6'b111111, 7'b0000000, 1'b0},
    {6'b001000, 7'b1000000, 1'b0},
    {6'b000000, 7'b1111111, 1'b0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic rd_stat();
    rd_stat_i = 1'b1; tick(); rd_stat_i = 1'b0;
  endtask

  task automatic wr_stat(logic [6:0] d);
    wr_stat_i = 1'b1; wr_data_i = d; tick(); wr_stat_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse(logic [5:0] ev);
    ch_evt_i = ev; tick(); ch_evt_i = '0;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R11 cnt", cnt_o, 0);
    chk("R11 stat", stat_o, 0);
    chk("R11 irq", irq_o, 0);
    rst_n = 1'b1;
    // R1: limit 4, wrap after five edges
    repeat (4) tick();
    chk("R1 cnt at limit", cnt_o, 4);
    chk("R1 no ovf yet", stat_o[6], 0);
    tick();
    chk("R1 wrapped", cnt_o, 0);
    chk("R1 ovf set", stat_o[6], 1);
    chk("R3 ovf irq masked", irq_o, 0);
    ien_i = 7'h40; #1;
    chk("R3 ovf irq enabled", irq_o, 1);
    mod_val = 16'hFFFF;
    rd_stat(); wr_stat(7'h00);
    chk("R4 ovf cleared", stat_o, 0);
    // R2/R3 vector walk
    for (int v = 0; v < 9; v++) begin
      ien_i = VEC[v][7:1];
      pulse(VEC[v][13:8]);
      #1;
      chk("R2 channel flags", stat_o[5:0], VEC[v][13:8]);
      chk("R3 irq gate", irq_o, VEC[v][0]);
      rd_stat(); wr_stat(7'h00);
    end
    ien_i = '0;
    chk("R4 all cleared", stat_o, 0);
    // R6 halt: freeze, capture ignored, compare still sets
    ch_is_cap_i = 6'b000001;
    halt_i = 1'b1; held = cnt_o;
    pulse(6'b000011); tick();
    chk("R6 cnt frozen", cnt_o, held);
    chk("R6 cap blocked cmp set", stat_o[1:0], 2'b10);
    halt_i = 1'b0; tick();
    chk("R6 resumes", cnt_o, held + 1);
    // R4 two-step
    wr_stat(7'h00);
    chk("R4 no read no clear", stat_o[1], 1);
    rd_stat(); wr_stat(7'h00);
    chk("R4 read then write clears", stat_o[1], 0);
    pulse(6'b001000); rd_stat(); wr_stat(7'h7F);
    chk("R4 write one keeps", stat_o[3], 1);
    wr_stat(7'h00);
    chk("R4 write disarms", stat_o[3], 1);
    // R5 set wins
    pulse(6'b000001); rd_stat();
    ch_evt_i = 6'b000001; wr_stat(7'h00); ch_evt_i = '0;
    chk("R5 set beats clear", stat_o[0], 1);
    // R7 protected halt, armed before
    pulse(6'b000100); rd_stat();
    halt_i = 1'b1; clr_en_i = 1'b0;
    rd_stat(); wr_stat(7'h00);
    chk("R7 flag kept in halt", stat_o[2], 1);
    halt_i = 1'b0;
    wr_stat(7'h00);
    chk("R7 clears after halt", stat_o[2], 0);
    // R7 read in protected halt does not arm
    pulse(6'b010000);
    halt_i = 1'b1; rd_stat(); halt_i = 1'b0;
    wr_stat(7'h00);
    chk("R7 halt read no arm", stat_o[4], 1);
    // R8 clearing permitted in halt
    pulse(6'b100000);
    halt_i = 1'b1; clr_en_i = 1'b1;
    rd_stat(); wr_stat(7'h00);
    chk("R8 cleared in halt", stat_o[5], 0);
    halt_i = 1'b0; clr_en_i = 1'b0; tick();
    chk("R8 stays cleared", stat_o[5], 0);
    // R9 stop
    stop_i = 1'b1; held = cnt_o;
    pulse(6'b000010); tick(); tick();
    chk("R9 cnt held", cnt_o, held);
    chk("R9 event ignored", stat_o[1], 0);
    stop_i = 1'b0; tick();
    chk("R9 resumes", cnt_o, held + 1);
    // R10 forced pin
    max_duty_i = 6'b000011; tov_i = 6'b000101; cmp_pin_i = 6'b100000; #1;
    chk("R10 pin force", pin_o, 6'b100001);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule